// File: doc/BRIEF.md
# Single-Wire Claim Receiver

The block listens to a shared open-drain style line that rests high when nobody owns it. It never drives the line. It samples the line through a two-stage synchronizer and watches for a falling edge. A node claims the line by holding it low for a long takeover period. Contending nodes may first emit short probe pulses. The receiver times each low and accepts a claim only after the low has lasted half the takeover period. It ignores short probes. If the line then sits high for the release period, it treats the episode as a false alarm.

After a valid claim, the sender rises and transmits eight return-to-zero bits, least significant bit first. Each bit is a high gap followed by a low phase. The width of the low phase carries the bit value. When the eighth low ends, the byte appears on `rx_data` with a one-cycle `rx_valid` strobe. A low phase or a gap that runs too long aborts the byte with a one-cycle `frame_err` pulse. `bus_free` reports that the receiver is idle and the line has stayed high for the release period.

The controller has six named states. ST_IDLE goes to ST_QUALIFY on a falling edge. ST_QUALIFY goes to ST_CLAIMED once the low reaches the qualify length, or to ST_PROBE if the line rises first. ST_PROBE goes back to ST_QUALIFY on the next low, or to ST_IDLE once the high reaches the release length. ST_CLAIMED goes to ST_GAP on the rising edge and clears the bit counter. ST_GAP goes to ST_BIT_LOW on a low, or to ST_IDLE with an error if the gap is too long. ST_BIT_LOW goes back to ST_GAP on a rise, or to ST_IDLE on the eighth rise or on an over-long low.

Top module: `wire_claim_rx`

## Requirements
- R1: After reset, all outputs are 0. A falling edge seen in ST_IDLE moves the receiver to ST_QUALIFY, and `bus_free` falls one cycle after the first low sample.
- R2: A low counts as a claim once it has lasted TAKEOVER_CYC/2 consecutive samples. A low one sample shorter that is followed by a long high produces no byte and no error.
- R3: Short lows separated by highs shorter than RELEASE_CYC are probes. Each new low restarts the qualify count. Probes produce no strobe and no error, and a later full claim is received normally.
- R4: A high of RELEASE_CYC samples that follows an unqualified low returns the receiver to ST_IDLE with `bus_free` high. No strobe and no error are produced.
- R5: A bit's value is decided by the length L of its low phase in samples: L > BIT_CYC/2 gives 1, otherwise 0. The first bit received lands in `rx_data[0]`.
- R6: A bit low that exceeds BIT_CYC samples aborts the byte with a one-cycle `frame_err` and no `rx_valid`.
- R7: A high gap that exceeds BIT_CYC samples while bits are expected (including before the first bit) aborts with a one-cycle `frame_err`. A gap of exactly BIT_CYC is accepted.
- R8: The rise that ends the eighth low loads `rx_data` and raises `rx_valid` for exactly one cycle. `rx_data` then holds until the next byte.
- R9: `bus_free` is 1 exactly when the receiver is in ST_IDLE and the synchronized line has been high for at least RELEASE_CYC consecutive samples. It is registered, and the line is seen two cycles after it arrives at `line_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Shared line as seen by the receiver (1 = released) |
| rx_data | output | DATA_W | Last received byte, first bit in bit 0 |
| rx_valid | output | 1 | One-cycle strobe when a byte completes |
| frame_err | output | 1 | One-cycle strobe when a byte is aborted |
| bus_free | output | 1 | Receiver idle and line released long enough |

## Verification
The bench targets the exact decision boundaries. It sends bit lows of BIT_CYC/2, BIT_CYC/2+1 and BIT_CYC samples. It sends gaps of BIT_CYC and BIT_CYC+1. It sends claim lows one sample short of the qualify length and exactly at it. Off-by-one errors in these comparisons show up as a flipped data bit, a spurious error, or a missed claim. Probe trains test that each new low restarts qualification. A design that kept counting across probes would take a byte from noise. False alarms followed by a long high test that `bus_free` comes back. The per-cycle reference model also catches a strobe that is stretched or shifted by a cycle.

// File: rtl/wcr_pkg.sv
`timescale 1ns/1ps
package wcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUALIFY,
        ST_PROBE,
        ST_CLAIMED,
        ST_GAP,
        ST_BIT_LOW
    } wcr_state_e;

endpackage

// File: rtl/wcr_line_sync.sv
`timescale 1ns/1ps
module wcr_line_sync #(
    parameter int CNT_W   = 6,
    parameter int CNT_MAX = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             ln,
    output logic             fall,
    output logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] run
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

    logic s1, s2, ln_q;
    logic chg;

    // two-stage synchronizer, resting level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            ln_q <= 1'b1;
        end else begin
            s1   <= line_in;
            s2   <= s1;
            ln_q <= s2;
        end
    end

    assign ln   = s2;
    assign chg  = (s2 != ln_q);
    assign fall = chg && !s2;

    // length of the current level run, including the present sample
    always_comb begin
        if (chg)
            len = CNT_W'(1);
        else if (run >= SAT)
            len = SAT;
        else
            len = run + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run <= '0;
        else
            run <= len;
    end

endmodule

// File: rtl/wcr_shifter.sv
`timescale 1ns/1ps
module wcr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] shifted,
    output logic              last
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] acc;
    logic [IDX_W-1:0]  idx;

    assign shifted = {bit_in, acc[DATA_W-1:1]};
    assign last    = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (clr) begin
            acc <= '0;
            idx <= '0;
        end else if (shift_en) begin
            acc <= shifted;
            idx <= last ? '0 : idx + IDX_W'(1);
        end
    end

    // R8: a completed word always restarts the index
    a_r8_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr && last) |=> (idx == '0));

endmodule

// File: rtl/wire_claim_rx.sv
`timescale 1ns/1ps
module wire_claim_rx
    import wcr_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TAKEOVER_CYC = 40,
    parameter int BIT_CYC      = 16,
    parameter int RELEASE_CYC  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              bus_free
);
    localparam int CNT_MAX = (RELEASE_CYC > BIT_CYC + 1) ? RELEASE_CYC : BIT_CYC + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] QUAL_L = CNT_W'(TAKEOVER_CYC / 2);
    localparam logic [CNT_W-1:0] HALF_L = CNT_W'(BIT_CYC / 2);
    localparam logic [CNT_W-1:0] BIT_L  = CNT_W'(BIT_CYC);
    localparam logic [CNT_W-1:0] REL_L  = CNT_W'(RELEASE_CYC);

    logic             ln, fall;
    logic [CNT_W-1:0] len, run;
    logic             sh_clr, sh_en, sh_last, bit_val;
    logic [DATA_W-1:0] sh_word;
    logic             set_valid, set_err;

    wcr_state_e state, state_n;

    wcr_line_sync #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .ln(ln), .fall(fall), .len(len), .run(run)
    );

    // on the rising sample, run holds the length of the low just ended
    assign bit_val = (run > HALF_L);

    wcr_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
        .bit_in(bit_val), .shifted(sh_word), .last(sh_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // transitions
    always_comb begin
        state_n   = state;
        sh_clr    = 1'b0;
        sh_en     = 1'b0;
        set_valid = 1'b0;
        set_err   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall)
                    state_n = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (ln)
                    state_n = ST_PROBE;
                else if (len >= QUAL_L)
                    state_n = ST_CLAIMED;
            end
            ST_PROBE: begin
                if (!ln)
                    state_n = ST_QUALIFY;
                else if (len >= REL_L)
                    state_n = ST_IDLE;
            end
            ST_CLAIMED: begin
                if (ln) begin
                    state_n = ST_GAP;
                    sh_clr  = 1'b1;
                end
            end
            ST_GAP: begin
                if (!ln)
                    state_n = ST_BIT_LOW;
                else if (len > BIT_L) begin
                    set_err = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_BIT_LOW: begin
                if (ln) begin
                    sh_en = 1'b1;
                    if (sh_last) begin
                        set_valid = 1'b1;
                        state_n   = ST_IDLE;
                    end else begin
                        state_n = ST_GAP;
                    end
                end else if (len > BIT_L) begin
                    set_err = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            bus_free  <= 1'b0;
        end else begin
            rx_valid  <= set_valid;
            frame_err <= set_err;
            if (set_valid)
                rx_data <= sh_word;
            bus_free  <= (state_n == ST_IDLE) && ln && (len >= REL_L);
        end
    end

    // R1: a falling edge while idle starts qualification
    a_r1_idle_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fall) |=> (state == ST_QUALIFY));

    // R3: probing never yields a strobe
    a_r3_probe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE) |-> (!rx_valid && !frame_err));

    // R6 / R7: errors only come out of the data phase
    a_r6_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ($past(state) == ST_GAP || $past(state) == ST_BIT_LOW));

    // R8: valid is one cycle wide and follows the last bit low
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r8_valid_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state) == ST_BIT_LOW));
    a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && frame_err));

    // R9: a low line withdraws the free flag on the next cycle
    a_r9_free_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && !ln) |=> !bus_free);

endmodule

// File: tb/wire_claim_rx_tb.sv
`timescale 1ns/1ps
module wire_claim_rx_tb;
    localparam int DW   = 8;
    localparam int TK   = 40;
    localparam int BC   = 16;
    localparam int REL  = 48;
    localparam int QUAL = TK / 2;
    localparam int HALF = BC / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_in = 1'b1;
    logic [DW-1:0] rx_data;
    logic          rx_valid, frame_err, bus_free;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    wire_claim_rx #(.DATA_W(DW), .TAKEOVER_CYC(TK), .BIT_CYC(BC), .RELEASE_CYC(REL)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err), .bus_free(bus_free)
    );

    // reference model: phases 0 idle, 1 qualify, 2 probe, 3 claimed, 4 gap, 5 bit low
    bit  hist[$];
    int  m_ph, m_run, m_nbits, m_acc;
    bit  m_prev;
    bit  e_valid, e_err, e_free;
    int  e_data;
    bit  model_on = 0;

    int valid_cnt = 0;
    int err_cnt   = 0;
    int last_data = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        hist.delete();
        hist.push_back(1'b1);
        hist.push_back(1'b1);
        m_ph = 0; m_run = 0; m_prev = 1'b1; m_nbits = 0; m_acc = 0;
        e_valid = 0; e_err = 0; e_free = 0; e_data = 0;
    endtask

    task automatic model_step(input bit s);
        int prevrun;
        bit b;
        prevrun = m_run;
        m_run   = (s != m_prev) ? 1 : m_run + 1;
        e_valid = 0;
        e_err   = 0;
        case (m_ph)
            0: if (!s && m_prev) m_ph = 1;
            1: if (s) m_ph = 2; else if (m_run >= QUAL) m_ph = 3;
            2: if (!s) m_ph = 1; else if (m_run >= REL) m_ph = 0;
            3: if (s) begin m_ph = 4; m_nbits = 0; m_acc = 0; end
            4: if (!s) m_ph = 5; else if (m_run > BC) begin e_err = 1; m_ph = 0; end
            5: if (s) begin
                   b = (prevrun > HALF);
                   if (b) m_acc = m_acc | (1 << m_nbits);
                   m_nbits++;
                   if (m_nbits == DW) begin e_valid = 1; e_data = m_acc; m_ph = 0; end
                   else m_ph = 4;
               end else if (m_run > BC) begin e_err = 1; m_ph = 0; end
            default: m_ph = 0;
        endcase
        e_free = (m_ph == 0) && s && (m_run >= REL);
        m_prev = s;
    endtask

    task automatic tick(input bit v);
        bit s;
        line_in = v;
        hist.push_back(v);
        s = hist.pop_front();
        @(posedge clk);
        if (model_on) model_step(s);
        @(negedge clk);
        if (model_on) begin
            chk(rx_valid == e_valid, "R8 rx_valid", rx_valid, e_valid);
            chk(rx_data == DW'(e_data), "R5 rx_data", rx_data, e_data);
            chk(frame_err == e_err, "R6/R7 frame_err", frame_err, e_err);
            chk(bus_free == e_free, "R9 bus_free", bus_free, e_free);
        end
        if (rx_valid) begin valid_cnt++; last_data = rx_data; end
        if (frame_err) err_cnt++;
    endtask

    task automatic drive(input bit v, input int n);
        for (int i = 0; i < n; i++) tick(v);
    endtask

    task automatic send_byte(input logic [DW-1:0] b, input int tk, input int l1,
                             input int l0, input int gp);
        drive(1'b0, tk);
        for (int i = 0; i < DW; i++) begin
            drive(1'b1, gp);
            drive(1'b0, b[i] ? l1 : l0);
        end
        drive(1'b1, REL + 4);
    endtask

    initial begin
        int v0, e0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rx_valid == 1'b0 && frame_err == 1'b0 && bus_free == 1'b0 && rx_data == '0,
            "R1 reset outputs", {rx_valid, frame_err, bus_free}, 0);
        rst_n = 1'b1;
        model_on = 1;
        drive(1'b1, REL + 4);
        chk(bus_free == 1'b1, "R9 free after release", bus_free, 1);

        // R1: free drops after a fall
        drive(1'b0, 4);
        chk(bus_free == 1'b0, "R1 free drops on low", bus_free, 0);
        drive(1'b1, REL + 4);

        // R5 R8: nominal byte
        v0 = valid_cnt;
        send_byte(8'hA5, TK, 12, 4, 8);
        chk(valid_cnt == v0 + 1, "R8 one strobe", valid_cnt - v0, 1);
        chk(last_data == 8'hA5, "R5 byte A5", last_data, 8'hA5);

        // R5: threshold lows HALF (zero) and HALF+1 (one)
        send_byte(8'h0F, TK, HALF + 1, HALF, 6);
        chk(last_data == 8'h0F, "R5 threshold 0F", last_data, 8'h0F);

        // R5 R7: max low and max gap accepted
        e0 = err_cnt;
        send_byte(8'hF0, TK, BC, 1, BC);
        chk(last_data == 8'hF0 && err_cnt == e0, "R7 max gap F0", last_data, 8'hF0);

        send_byte(8'h00, TK, 12, 3, 5);
        chk(last_data == 8'h00, "R5 byte 00", last_data, 0);
        send_byte(8'hFF, TK, 10, 3, 5);
        chk(last_data == 8'hFF, "R5 byte FF", last_data, 8'hFF);

        // R3: probe pulses then a real claim
        v0 = valid_cnt; e0 = err_cnt;
        drive(1'b0, 3); drive(1'b1, 2); drive(1'b0, QUAL - 1); drive(1'b1, 3);
        drive(1'b0, 5); drive(1'b1, 2);
        chk(valid_cnt == v0 && err_cnt == e0, "R3 probes quiet", valid_cnt - v0, 0);
        send_byte(8'h3C, TK, 12, 4, 8);
        chk(valid_cnt == v0 + 1 && last_data == 8'h3C, "R3 claim after probes", last_data, 8'h3C);

        // R4: false alarm
        v0 = valid_cnt; e0 = err_cnt;
        drive(1'b0, 10); drive(1'b1, REL + 4);
        chk(bus_free == 1'b1 && valid_cnt == v0 && err_cnt == e0, "R4 false alarm", bus_free, 1);

        // R2: one short of qualify, then exactly qualify
        drive(1'b0, QUAL - 1); drive(1'b1, 8);
        for (int i = 0; i < DW; i++) begin drive(1'b0, 5); drive(1'b1, 5); end
        drive(1'b1, REL + 4);
        chk(valid_cnt == v0 && err_cnt == e0, "R2 short claim ignored", valid_cnt - v0, 0);
        send_byte(8'h5A, QUAL, 12, 4, 8);
        chk(valid_cnt == v0 + 1 && last_data == 8'h5A, "R2 exact claim", last_data, 8'h5A);

        // R6: over-long bit low
        v0 = valid_cnt; e0 = err_cnt;
        drive(1'b0, TK); drive(1'b1, 4); drive(1'b0, BC + 1); drive(1'b1, REL + 4);
        chk(err_cnt == e0 + 1 && valid_cnt == v0, "R6 long low", err_cnt - e0, 1);

        // R7: over-long gap mid byte and before first bit
        drive(1'b0, TK); drive(1'b1, 4); drive(1'b0, 4); drive(1'b1, 4); drive(1'b0, 12);
        drive(1'b1, REL + 4);
        chk(err_cnt == e0 + 2 && valid_cnt == v0, "R7 long gap", err_cnt - e0, 2);
        drive(1'b0, TK); drive(1'b1, REL + 4);
        chk(err_cnt == e0 + 3 && bus_free == 1'b1, "R7 gap after claim", err_cnt - e0, 3);

        // R8: data holds after error
        chk(last_data == 8'h5A && rx_data == 8'h5A, "R8 data holds", rx_data, 8'h5A);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule